// File: doc/BRIEF.md
# Bank Parity and Write-Protect Guard

This block sits beside the data path of a multi-bank memory controller and watches every bus access aimed at one of its banks. On a write it produces one parity bit per byte lane in the same cycle as the data, so the controller can store the bits next to the data. On a read it compares the returned parity lines against parity recomputed from the returned data. The comparison is registered, and a mismatch is reported one clock later. A separate attribute per bank marks the bank write-protected. A write to such a bank is held back from memory and reported in the same way.

Each error pulses a transfer-error output for one cycle and sets sticky status bits. A status bit records the bank, and a second bit records whether the failing read was a data fetch or an instruction fetch. Software clears the bits by writing ones. Parity is switched on bank by bank, and one global input selects odd or even sense. Only accesses started by masters inside the chip are checked. Only the byte lanes that the transfer size and address offset select take part.

The reporting stage is a three-state machine. `S_QUIET` means no error is pending. `S_PAR_FAULT` means the previous access was a read with a parity mismatch. `S_WP_FAULT` means the previous access was a write to a protected bank. The machine is re-evaluated on every clock. A bad read sends it to `S_PAR_FAULT`, a protected write sends it to `S_WP_FAULT`, and any other cycle sends it to `S_QUIET`. This holds from every state, so two faulting accesses in a row keep the error output high. `tea` is high in both fault states.

Top module: `mem_bank_guard`

## Requirements
- R1: While `acc_valid` and `acc_write` are high and the addressed bank has `cfg_par_en` set, `par_out[i]` equals the XOR of bits `bus_data[8*i+7:8*i]`, combinationally in the same cycle. This holds for each enabled lane i; lane 0 is bits 7:0. Otherwise `par_out[i]` is 0.
- R2: With `cfg_odd`=1 every generated and expected parity bit is the inverse of the even-sense value given in R1. `cfg_odd` applies to all banks alike.
- R3: Lane i takes part in an access when `(i >> acc_size) == (acc_offset >> acc_size)`. The size codes are 0=byte, 1=halfword and 2=word. A read mismatch on a lane that does not take part, or on a bank without `cfg_par_en`, is never flagged.
- R4: A read with `acc_internal`=0 never raises `tea` and never sets a status bit, whatever `par_in` holds.
- R5: A checked read (internal master, parity-enabled bank) in which some participating lane has `par_in[i]` different from its expected parity raises `tea` in the cycle after the access. `tea` stays high for exactly that one cycle unless the next access also faults.
- R6: Such a parity error sets `stat[bank]`. It also sets `stat[2*BANKS+1]` if `acc_instr`=1, or `stat[2*BANKS]` if `acc_instr`=0. Status changes are visible in the cycle after the access.
- R7: A write to a bank with `cfg_wp` set drives `wr_allow` low in the same cycle. It raises `tea` for one cycle afterwards and sets `stat[BANKS+bank]`. A write to an unprotected bank drives `wr_allow` high and raises no error. Protection applies to internal and external masters alike.
- R8: Status bits are sticky. Bit j clears only in a cycle with `clr_valid` high and `clr_bits[j]`=1. A new error that sets the same bit in that cycle wins over the clear.
- R9: After reset `stat` is all zero and `tea` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is on the bus this cycle |
| acc_bank | input | 3 | Index of the bank being accessed |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_internal | input | 1 | 1 = access started by an on-chip master |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_offset | input | 2 | Low address bits selecting the first lane |
| bus_data | input | 32 | Data on the bus |
| par_in | input | 4 | Parity lines returned with read data |
| cfg_par_en | input | 8 | Per-bank parity enable |
| cfg_wp | input | 8 | Per-bank write-protect |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| clr_valid | input | 1 | Software status clear strobe |
| clr_bits | input | 18 | Write-one-to-clear mask, same layout as `stat` |
| par_out | output | 4 | Generated parity for write data |
| wr_allow | output | 1 | Write may proceed to memory |
| tea | output | 1 | Transfer-error pulse, one cycle after a faulting access |
| stat | output | 18 | [7:0] parity error per bank, [15:8] write-protect violation per bank, [16] data parity, [17] instruction parity |

## Verification
The bench sweeps every bank, both parity senses, every size and offset pair, and all sixteen `par_in` patterns. Configuration masks mix enabled and protected banks. This catches a lane mask that ignores the offset: such a design would flag mismatches on lanes outside a byte or halfword transfer. It also catches a check that forgets the internal-master gate, which would flag external reads. Clears are issued pseudo-randomly in the same cycles as faulting accesses. A design that lets the clear win would then lose a fresh error bit. A design that clears bits not in the mask would drop older errors. Back-to-back faults and the idle cycles after them show whether `tea` is a true one-cycle pulse or is left stuck high.

// File: rtl/mbg_pkg.sv
package mbg_pkg;
    typedef enum logic [1:0] {
        S_QUIET     = 2'd0,
        S_PAR_FAULT = 2'd1,
        S_WP_FAULT  = 2'd2
    } guard_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/mbg_lane_parity.sv
module mbg_lane_parity #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0] data,
    input  logic                    odd,
    output logic [LANES-1:0]        gen
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign gen[i] = (^data[i*BYTE_W +: BYTE_W]) ^ odd;
    end
endmodule

// File: rtl/mbg_status.sv
module mbg_status #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic         clr_valid,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] stat
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_valid ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_eff) | set_bits;
    end

    // R8: a bit not named in the clear stays set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(stat & ~clr_eff)) == $past(stat & ~clr_eff)));

    // R8: a new error beats a simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((stat & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/mem_bank_guard.sv
module mem_bank_guard #(
    parameter int unsigned BANKS  = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned BANK_W = $clog2(BANKS),
    localparam int unsigned OFF_W  = $clog2(LANES),
    localparam int unsigned DATA_W = LANES * BYTE_W,
    localparam int unsigned STAT_W = 2 * BANKS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic              acc_write,
    input  logic              acc_instr,
    input  logic              acc_internal,
    input  logic [1:0]        acc_size,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [LANES-1:0]  par_in,
    input  logic [BANKS-1:0]  cfg_par_en,
    input  logic [BANKS-1:0]  cfg_wp,
    input  logic              cfg_odd,
    input  logic              clr_valid,
    input  logic [STAT_W-1:0] clr_bits,
    output logic [LANES-1:0]  par_out,
    output logic              wr_allow,
    output logic              tea,
    output logic [STAT_W-1:0] stat
);
    import mbg_pkg::*;

    localparam int unsigned DPAR_BIT = 2 * BANKS;
    localparam int unsigned IPAR_BIT = 2 * BANKS + 1;

    guard_state_e state_q, state_d;
    logic [LANES-1:0]  lane_on;
    logic [LANES-1:0]  gen;
    logic [LANES-1:0]  mismatch;
    logic              bank_pe, bank_wp;
    logic              rd_bad, wp_bad;
    logic [STAT_W-1:0] set_bits;

    // lane participation from size and offset
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
        assign lane_on[i] = (IDX >> acc_size) == (acc_offset >> acc_size);
    end

    mbg_lane_parity #(.LANES(LANES), .BYTE_W(BYTE_W)) u_par (
        .data (bus_data),
        .odd  (cfg_odd),
        .gen  (gen)
    );

    assign bank_pe  = cfg_par_en[acc_bank];
    assign bank_wp  = cfg_wp[acc_bank];
    assign mismatch = (gen ^ par_in) & lane_on;
    assign rd_bad   = acc_valid && !acc_write && acc_internal && bank_pe && (|mismatch);
    assign wp_bad   = acc_valid && acc_write && bank_wp;
    assign wr_allow = acc_valid && acc_write && !bank_wp;
    assign par_out  = (acc_valid && acc_write && bank_pe) ? (gen & lane_on) : '0;

    always_comb begin
        set_bits = '0;
        if (rd_bad) begin
            set_bits[acc_bank] = 1'b1;
            if (acc_instr) set_bits[IPAR_BIT] = 1'b1;
            else           set_bits[DPAR_BIT] = 1'b1;
        end
        if (wp_bad) set_bits[BANKS + int'(acc_bank)] = 1'b1;
    end

    mbg_status #(.W(STAT_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_bits  (set_bits),
        .clr_valid (clr_valid),
        .clr_bits  (clr_bits),
        .stat      (stat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_QUIET;
        else        state_q <= state_d;
    end

    // transitions: every state re-evaluates on the current access
    always_comb begin
        state_d = S_QUIET;
        unique case (state_q)
            S_QUIET, S_PAR_FAULT, S_WP_FAULT: begin
                if (rd_bad)      state_d = S_PAR_FAULT;
                else if (wp_bad) state_d = S_WP_FAULT;
                else             state_d = S_QUIET;
            end
            default: state_d = S_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        tea = 1'b0;
        unique case (state_q)
            S_QUIET:     tea = 1'b0;
            S_PAR_FAULT: tea = 1'b1;
            S_WP_FAULT:  tea = 1'b1;
            default:     tea = 1'b0;
        endcase
    end

    a_r4_external_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_internal) |=> !tea);

    a_r5_parity_tea: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_internal && cfg_par_en[acc_bank]
         && (|((par_in ^ par_out ^ gen) & lane_on & ~par_out) || |(mismatch))) |=> tea);

    a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && cfg_wp[acc_bank]) |-> !wr_allow);

    a_r7_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && cfg_wp[acc_bank]) |=> (tea && stat[BANKS + int'($past(acc_bank))]));

    a_r1_lane0_even: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && cfg_par_en[acc_bank] && !cfg_odd && lane_on[0])
        |-> ((^{par_out[0], bus_data[BYTE_W-1:0]}) == 1'b0));

    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid) |=> !tea);
endmodule

// File: tb/mem_bank_guard_tb.sv
module mem_bank_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_bank = '0;
    logic        acc_write = 1'b0;
    logic        acc_instr = 1'b0;
    logic        acc_internal = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_offset = '0;
    logic [31:0] bus_data = '0;
    logic [3:0]  par_in = '0;
    logic [7:0]  cfg_par_en = 8'b0101_0101;
    logic [7:0]  cfg_wp = 8'b0011_0011;
    logic        cfg_odd = 1'b0;
    logic        clr_valid = 1'b0;
    logic [17:0] clr_bits = '0;
    logic [3:0]  par_out;
    logic        wr_allow;
    logic        tea;
    logic [17:0] stat;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    logic [17:0] m_stat = '0;
    logic [31:0] lcg = 32'h1234_5678;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mem_bank_guard u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bank(acc_bank),
        .acc_write(acc_write), .acc_instr(acc_instr), .acc_internal(acc_internal),
        .acc_size(acc_size), .acc_offset(acc_offset), .bus_data(bus_data),
        .par_in(par_in), .cfg_par_en(cfg_par_en), .cfg_wp(cfg_wp), .cfg_odd(cfg_odd),
        .clr_valid(clr_valid), .clr_bits(clr_bits), .par_out(par_out),
        .wr_allow(wr_allow), .tea(tea), .stat(stat)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] mask_of(input logic [1:0] sz, input logic [1:0] off);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = ((i >> sz) == (int'(off) >> sz));
        return m;
    endfunction

    function automatic logic [3:0] par_of(input logic [31:0] d, input logic odd);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(d[8*i+b]);
            p[i] = logic'(ones % 2) ^ odd;
        end
        return p;
    endfunction

    task automatic access(input logic wr, input logic [2:0] bk, input logic instr, input logic intl,
                          input logic [1:0] sz, input logic [1:0] off, input logic [3:0] pin,
                          input logic clr_v, input logic [17:0] clr_m);
        logic [3:0]  m, g, exp_par;
        logic        rd_bad, wp_bad;
        logic [17:0] set_m;
        @(negedge clk);
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        acc_valid = 1'b1; acc_write = wr; acc_bank = bk; acc_instr = instr;
        acc_internal = intl; acc_size = sz; acc_offset = off; bus_data = lcg;
        par_in = pin; clr_valid = clr_v; clr_bits = clr_m;
        m = mask_of(sz, off);
        g = par_of(lcg, cfg_odd);
        exp_par = (wr && cfg_par_en[bk]) ? (g & m) : 4'h0;
        rd_bad = !wr && intl && cfg_par_en[bk] && (|((g ^ pin) & m));
        wp_bad = wr && cfg_wp[bk];
        set_m = '0;
        if (rd_bad) begin
            set_m[bk] = 1'b1;
            set_m[instr ? 17 : 16] = 1'b1;
        end
        if (wp_bad) set_m[8 + int'(bk)] = 1'b1;
        #1;
        if (wr) begin
            check(par_out == exp_par, cfg_odd ? "R2 odd parity" : "R1 write parity", 32'(par_out), 32'(exp_par));
            check(wr_allow == !cfg_wp[bk], "R7 wr_allow", 32'(wr_allow), 32'(!cfg_wp[bk]));
        end
        @(posedge clk); #1;
        m_stat = (m_stat & ~(clr_v ? clr_m : 18'h0)) | set_m;
        if (!wr && !intl)
            check(tea == 1'b0, "R4 external read", 32'(tea), 32'h0);
        else if (wr)
            check(tea == wp_bad, "R7 protect tea", 32'(tea), 32'(wp_bad));
        else
            check(tea == rd_bad, "R3 R5 checked read tea", 32'(tea), 32'(rd_bad));
        check(stat == m_stat, (|set_m) ? "R6 R7 R8 status set" : "R8 status sticky", 32'(stat), 32'(m_stat));
    endtask

    task automatic idle_cycle;
        @(negedge clk);
        acc_valid = 1'b0; clr_valid = 1'b0;
        @(posedge clk); #1;
        check(tea == 1'b0, "R5 tea single pulse", 32'(tea), 32'h0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(stat == 18'h0, "R9 reset stat", 32'(stat), 32'h0);
        check(tea == 1'b0, "R9 reset tea", 32'(tea), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(stat == 18'h0 && tea == 1'b0, "R9 after release", 32'(stat), 32'h0);

        for (int od = 0; od < 2; od++) begin
            cfg_odd = logic'(od);
            for (int bk = 0; bk < 8; bk++)
                for (int sz = 0; sz < 3; sz++)
                    for (int off = 0; off < 4; off++) begin
                        for (int wr = 0; wr < 2; wr++)
                            access(1'b1, 3'(bk), 1'b0, logic'(wr), 2'(sz), 2'(off), 4'h0, 1'b0, 18'h0);
                        for (int intl = 0; intl < 2; intl++)
                            for (int ins = 0; ins < 2; ins++)
                                for (int p = 0; p < 16; p++) begin
                                    logic        cv;
                                    cv = lcg[7:5] == 3'd0;
                                    access(1'b0, 3'(bk), logic'(ins), logic'(intl), 2'(sz), 2'(off),
                                           4'(p), cv, cv ? lcg[27:10] : 18'h0);
                                end
                        idle_cycle();
                    end
        end

        // R8: clear-all in the same cycle as a protected write keeps the new bit
        access(1'b1, 3'd0, 1'b0, 1'b1, 2'd2, 2'd0, 4'h0, 1'b1, 18'h3FFFF);
        check(stat == 18'h00100, "R8 set beats clear", 32'(stat), 32'h100);
        idle_cycle();
        @(negedge clk); clr_valid = 1'b1; clr_bits = 18'h3FFFF;
        @(posedge clk); #1;
        check(stat == 18'h0, "R8 clear all", 32'(stat), 32'h0);
        clr_valid = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule